// File: doc/BRIEF.md
# Banked Memory Address Mapper

This block sits between a small CPU with a 10-bit address bus and a 64 KiB physical memory. The CPU sees 1 KiB, cut into two 512-byte halves. The lower half is a movable window that can show any one of 128 physical banks of 512 bytes. The upper half is a common area that always shows the last bank. A single bank number, held in a register inside the common area, chooses what the window shows.

The CPU's top address bit is never passed to memory. It only selects where the upper seven physical address bits come from: the bank register, or a fixed all-ones constant. The lower half of the bank numbers is ROM and the upper half is RAM. The chip select therefore follows the bank number and not the CPU address, and a program behaves the same whichever kind of bank it runs from.

The top 64 bytes of the common area are I/O space. Accesses there reach no memory chip. The highest address in that space holds the bank register. A write to it changes the mapping from the next access onward, and a read returns the current bank number.

Top module: `bank_mapper`

## Requirements
- R1: After a synchronous active-low reset the bank number is 0, so lower-half reads go to physical address 0x0000 plus the offset, with the ROM select active.
- R2: For a CPU address with bit 9 = 0, the physical address is {bank[6:0], cpu_addr[8:0]}.
- R3: For a CPU address with bit 9 = 1, the physical address is {7'h7F, cpu_addr[8:0]}, whatever the bank register holds.
- R4: Outside I/O space, a read asserts rom_cs when physical bit 15 is 0 (banks 0–63) and ram_cs when it is 1 (banks 64–127). A write to a RAM bank asserts ram_cs and ram_we.
- R5: A write that maps to a ROM bank asserts none of rom_cs, ram_cs and ram_we.
- R6: An access to CPU addresses 0x3C0–0x3FF asserts io_sel and no memory chip select.
- R7: A write to 0x3FF loads cpu_wdata[6:0] into the bank register on that clock edge, and bit 7 is discarded. The new mapping applies from the next cycle.
- R8: A read of 0x3FF returns {1'b0, bank} on cpu_rdata. At every other time cpu_rdata is 0.
- R9: A write to any I/O address other than 0x3FF leaves the bank register unchanged.
- R10: With neither cpu_rd nor cpu_wr asserted, no chip select, ram_we or io_sel is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 10 | CPU logical address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rdata | output | 8 | Bank register read-back, 0 when not selected |
| mem_addr | output | 16 | Physical memory address |
| rom_cs | output | 1 | ROM chip select |
| ram_cs | output | 1 | RAM chip select |
| ram_we | output | 1 | RAM write enable |
| io_sel | output | 1 | Access falls in I/O space |

## Verification
The bench targets the places where a mapper usually goes wrong. It sets a bank number with bit 7 high: a design that kept that bit would read it back as 0x85 instead of 0x05. It writes to I/O addresses next to the bank register: a loose address compare would move the window there. It writes into ROM banks: a design that does not gate writes would assert a chip select. It also maps bank 127 into the lower half and reads the common half while the window points elsewhere, which catches a mux that uses the wrong source for the upper address bits. Finally it checks that the mapping changes exactly one cycle after the write to the register, because a design with an extra pipeline stage would show the old bank for one more access.

// File: rtl/bankmap_pkg.sv
// Package: bankmap_pkg
// Shared default sizes and the chip-select bundle used by the mapper.
// Assumes a byte-wide CPU data bus.
package bankmap_pkg;
    localparam int DEF_ADDR_W   = 10;
    localparam int DEF_BANK_W   = 7;
    localparam int DEF_DATA_W   = 8;
    localparam int DEF_IO_BYTES = 64;

    typedef struct packed {
        logic rom;
        logic ram;
        logic we;
        logic io;
    } sel_t;
endpackage

// File: rtl/bank_select_reg.sv
// Module: bank_select_reg
// Holds the bank number shown in the lower window. It loads on a CPU
// write to the highest logical address and clears on synchronous
// active-low reset. Assumes wdata carries only the bank bits.
module bank_select_reg #(
    parameter int ADDR_W = 10,
    parameter int BANK_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] bank_q,
    output logic              reg_hit
);
    // Register decode: the bank register is the all-ones address.
    always_comb reg_hit = (cpu_addr == {ADDR_W{1'b1}});

    // Bank storage: clear on reset, load on a write that hits the register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_q <= '0;
        else if (cpu_wr && reg_hit)
            bank_q <= wdata;
    end

    a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> bank_q == '0);
    a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == {ADDR_W{1'b1}}) |=> bank_q == $past(wdata));
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr && cpu_addr == {ADDR_W{1'b1}}) |=> $stable(bank_q));
endmodule

// File: rtl/addr_translate.sv
// Module: addr_translate
// Builds the physical address from the CPU offset. The CPU's top address
// bit picks the bank register or the fixed common bank for the upper bits.
// Assumes the common bank is the highest bank number.
module addr_translate #(
    parameter int ADDR_W = 10,
    parameter int BANK_W = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic [BANK_W-1:0]        bank_q,
    output logic [BANK_W+ADDR_W-2:0] phys_addr
);
    localparam int OFF_W = ADDR_W - 1;
    localparam int PA_W  = BANK_W + OFF_W;
    localparam logic [BANK_W-1:0] COMMON_BANK = {BANK_W{1'b1}};

    logic [BANK_W-1:0] upper;

    // Upper-bit mux: window half uses the register, common half the constant.
    always_comb upper = cpu_addr[ADDR_W-1] ? COMMON_BANK : bank_q;

    // Concatenate the chosen bank with the in-block offset.
    always_comb phys_addr = {upper, cpu_addr[OFF_W-1:0]};

    a_r3_common_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr[ADDR_W-1] |-> phys_addr[PA_W-1:OFF_W] == COMMON_BANK);
    a_r2_window_bank: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_addr[ADDR_W-1] |-> phys_addr[PA_W-1:OFF_W] == bank_q);
endmodule

// File: rtl/cs_decode.sv
// Module: cs_decode
// Decodes the chip selects from the physical bank half and the CPU strobes.
// I/O space (the top IO_BYTES of the logical space) reaches no memory.
// Writes into ROM are dropped. Assumes that physical bit 15 selects RAM.
module cs_decode #(
    parameter int ADDR_W   = 10,
    parameter int IO_BYTES = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic                pa_msb,
    input  logic                cpu_rd,
    input  logic                cpu_wr,
    output bankmap_pkg::sel_t   sel
);
    localparam logic [ADDR_W-1:0] IO_BASE = ADDR_W'((1 << ADDR_W) - IO_BYTES);

    logic in_io;
    logic access;

    // Region decode: I/O window at the top of the logical space.
    always_comb in_io = (cpu_addr >= IO_BASE);

    // Any strobe marks a live bus cycle.
    always_comb access = cpu_rd || cpu_wr;

    // Chip-select generation from region, bank half and direction.
    always_comb begin
        sel.io  = access && in_io;
        sel.rom = cpu_rd && !in_io && !pa_msb;
        sel.ram = access && !in_io && pa_msb;
        sel.we  = cpu_wr && !in_io && pa_msb;
    end

    a_r5_rom_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr |-> !sel.rom);
    a_r6_io_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        sel.io |-> !(sel.rom || sel.ram || sel.we));
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_rd || cpu_wr) |-> sel == '0);
    a_r4_one_chip: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sel.rom, sel.ram, sel.io}) <= 1);
endmodule

// File: rtl/bank_mapper.sv
// Module: bank_mapper (top)
// Maps a 10-bit CPU address onto a 64 KiB banked physical space, drives
// the ROM/RAM/I/O selects, and serves the bank register. Outputs are
// combinational from the CPU address and the registered bank number.
module bank_mapper #(
    parameter int ADDR_W   = bankmap_pkg::DEF_ADDR_W,
    parameter int BANK_W   = bankmap_pkg::DEF_BANK_W,
    parameter int DATA_W   = bankmap_pkg::DEF_DATA_W,
    parameter int IO_BYTES = bankmap_pkg::DEF_IO_BYTES,
    localparam int PA_W    = BANK_W + ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [PA_W-1:0]   mem_addr,
    output logic              rom_cs,
    output logic              ram_cs,
    output logic              ram_we,
    output logic              io_sel
);
    logic [BANK_W-1:0]  bank_q;
    logic               reg_hit;
    bankmap_pkg::sel_t  sel;

    bank_select_reg #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_reg (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .wdata(cpu_wdata[BANK_W-1:0]), .bank_q(bank_q), .reg_hit(reg_hit)
    );

    addr_translate #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_xlate (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .bank_q(bank_q),
        .phys_addr(mem_addr)
    );

    cs_decode #(.ADDR_W(ADDR_W), .IO_BYTES(IO_BYTES)) u_cs (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .pa_msb(mem_addr[PA_W-1]),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .sel(sel)
    );

    // Unpack the select bundle onto the pins.
    always_comb begin
        rom_cs = sel.rom;
        ram_cs = sel.ram;
        ram_we = sel.we;
        io_sel = sel.io;
    end

    // Read-back: the bank number, zero-extended, only while reading the register.
    always_comb cpu_rdata = (cpu_rd && reg_hit) ? DATA_W'(bank_q) : '0;

    a_r8_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd |-> cpu_rdata == '0);
    a_r8_msb_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdata[DATA_W-1] == 1'b0);
endmodule

// File: tb/bank_mapper_test.sv
`timescale 1ns/100ps
module bank_mapper_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic       cpu_rd = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_rdata;
    logic [15:0] mem_addr;
    logic       rom_cs, ram_cs, ram_we, io_sel;

    int checks = 0;
    int fails  = 0;
    logic [6:0] bank_m = '0;
    bit done = 0;

    typedef struct {
        logic [15:0] pa;
        logic        rom, ram, we, io;
        logic [7:0]  rd;
        string       req;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    bank_mapper uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
        .mem_addr(mem_addr), .rom_cs(rom_cs), .ram_cs(ram_cs),
        .ram_we(ram_we), .io_sel(io_sel)
    );

    // Driver: apply one bus cycle after a rising edge and queue what the
    // requirements say the outputs must be during that cycle.
    task automatic op(input logic [9:0] a, input logic rd, input logic wr,
                      input logic [7:0] wd, input string req);
        exp_t e;
        logic io;
        @(posedge clk);
        #1;
        cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = wd;
        io = (a >= 10'h3C0);
        e.pa  = a[9] ? {7'h7F, a[8:0]} : {bank_m, a[8:0]};
        e.io  = (rd || wr) && io;
        e.rom = rd && !io && !e.pa[15];
        e.ram = (rd || wr) && !io && e.pa[15];
        e.we  = wr && !io && e.pa[15];
        e.rd  = (rd && a == 10'h3FF) ? {1'b0, bank_m} : 8'h00;
        e.req = req;
        q.push_back(e);
        if (wr && a == 10'h3FF) bank_m = wd[6:0];
    endtask

    // Monitor: compare mid-cycle, away from the active edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (mem_addr !== e.pa || rom_cs !== e.rom || ram_cs !== e.ram ||
                ram_we !== e.we || io_sel !== e.io || cpu_rdata !== e.rd) begin
                fails++;
                $display("FAIL %s: actual pa=%h rom=%b ram=%b we=%b io=%b rd=%h expected pa=%h rom=%b ram=%b we=%b io=%b rd=%h",
                    e.req, mem_addr, rom_cs, ram_cs, ram_we, io_sel, cpu_rdata,
                    e.pa, e.rom, e.ram, e.we, e.io, e.rd);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        op(10'h3FF, 1, 0, 0, "R1 reset bank reads 0");         // R8 too
        op(10'h010, 1, 0, 0, "R1 reset window is ROM bank 0");
        op(10'h3FF, 0, 1, 8'h05, "R7 set bank 5");
        op(10'h123, 1, 0, 0, "R2 bank 5 window read");        // 0x0B23, ROM
        op(10'h123, 0, 1, 8'hAA, "R5 write to ROM bank dropped");
        op(10'h3FF, 0, 1, 8'h40, "R7 set bank 64");
        op(10'h1FF, 1, 0, 0, "R4 RAM read bank 64");           // 0x81FF
        op(10'h050, 0, 1, 8'h11, "R4 RAM write bank 64");
        op(10'h200, 1, 0, 0, "R3 common low byte");            // 0xFE00
        op(10'h3BF, 0, 1, 8'h22, "R3 common last RAM byte");
        op(10'h3C0, 1, 0, 0, "R6 io base read");
        op(10'h3C5, 0, 1, 8'h7F, "R9 io write elsewhere");
        op(10'h3FE, 0, 1, 8'h01, "R9 io write next to reg");
        op(10'h3FF, 1, 0, 0, "R9 bank still 64");
        op(10'h3FF, 0, 1, 8'h85, "R7 bit7 discarded");
        op(10'h3FF, 1, 0, 0, "R8 read back 0x05");
        op(10'h000, 1, 0, 0, "R7 new bank applies next cycle");
        op(10'h3FF, 0, 1, 8'h7F, "R7 set bank 127");
        op(10'h000, 1, 0, 0, "R2 common bank in window");      // 0xFE00
        op(10'h155, 0, 0, 0, "R10 idle no selects");
        op(10'h3FF, 0, 0, 0, "R10 idle on reg address");
        for (int b = 0; b < 128; b += 9) begin
            op(10'h3FF, 0, 1, 8'(b), "R7 sweep set");
            op(10'h0AA, 1, 0, 0, "R2 sweep window");
            op(10'h2AA, 1, 0, 0, "R3 sweep common");
        end
        @(posedge clk);
        #1 cpu_rd = 0; cpu_wr = 0;
        repeat (3) @(posedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule